// File: doc/BRIEF.md
# Bit-Serial Transposed CAM Search Engine

This block is a content-addressable memory. Its keys are kept in bit-sliced form: storage row k holds bit k of every entry, so a row is as wide as the entry count and there are as many rows as the key has bits. A lookup begins with a start strobe. The search key then arrives one bit per accepted cycle, least significant bit first. Each accepted bit reads one row and compares it against the incoming bit in every column at once. A per-entry match flag survives only while all compares so far agree.

After the last key bit the block raises a one-cycle completion pulse. With that pulse it reports whether any entry survived, and the index of the lowest surviving entry. Keys are stored through a write request that carries an entry index and a full key. The block applies the key one row per cycle as read-modify-write steps on that entry's column. Writes and searches never overlap: while the engine is busy, new requests are dropped.

Top module: `bs_cam_top`

## Requirements
- R1: After synchronous reset `busy` and `done` are 0 and every entry is invalid.
- R2: A write request taken while idle keeps `busy` high for exactly KEY_W cycles after the request cycle. Afterwards the entry holds the new key and is valid.
- R3: A search taken while idle consumes KEY_W cycles with `key_vld`=1, bit 0 of the key first. Cycles with `key_vld`=0 stall it. `done` is high for exactly one cycle, the cycle after the last key bit is consumed.
- R4: A valid entry whose stored key equals the searched key produces `hit`=1 with `hit_idx` equal to that entry's index, including entry 0 and entry ENTRIES-1.
- R5: When several valid entries hold the searched key, `hit_idx` is the lowest of their indices.
- R6: When no valid entry matches, `hit`=0 and `hit_idx`=0 during the `done` cycle.
- R7: While `busy` is high, `srch_start` and `wr_req` are ignored: no search result appears and no entry changes.
- R8: If `srch_start` and `wr_req` are both high in the same idle cycle, the search is taken and the write is dropped.
- R9: Invalid entries never match, even when their all-zero contents equal the key.
- R10: Writing an entry that already holds a key replaces that key completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| srch_start | input | 1 | Begin a search (taken when idle) |
| key_vld | input | 1 | Serial key bit present this cycle |
| key_bit | input | 1 | Serial key bit, LSB first |
| wr_req | input | 1 | Store a key (taken when idle) |
| wr_idx | input | $clog2(ENTRIES) | Target entry for the write |
| wr_key | input | KEY_W | Key to store |
| busy | output | 1 | A search or write is in progress |
| done | output | 1 | One-cycle search completion pulse |
| hit | output | 1 | Some valid entry matched (only with done) |
| hit_idx | output | $clog2(ENTRIES) | Lowest matching entry (0 when no hit) |

## Verification
Suppose one storage bit in a column were wrong, or a match flag were set again after it had cleared. The damage would show only at the next search completion that uses that column, as a wrong `hit` or a `hit_idx` that points at a higher or lower entry. That is KEY_W bit cycles after the start. A validity flag that is wrong shows the same way, as a hit on an entry that was never written or at reset. A sequencing fault in the write path shows at once as a `busy` window longer or shorter than KEY_W cycles. A missed stall or a miscounted bit position makes `done` appear in the wrong cycle.

// File: rtl/bs_cam_pkg.sv
package bs_cam_pkg;

    localparam int unsigned KEY_W_DEFAULT   = 48;
    localparam int unsigned ENTRIES_DEFAULT = 1024;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SRCH  = 2'd1,
        ST_WRITE = 2'd2,
        ST_FIN   = 2'd3
    } cam_state_e;

    // Bits needed to index n items, never less than one.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/bs_cam_rows.sv
module bs_cam_rows #(
    parameter int unsigned KEY_W   = 48,
    parameter int unsigned ENTRIES = 1024,
    parameter int unsigned CW      = 6,
    parameter int unsigned IW      = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CW-1:0]      rd_sel,
    output logic [ENTRIES-1:0] rd_row,
    input  logic               wr_en,
    input  logic [CW-1:0]      wr_sel,
    input  logic [IW-1:0]      wr_col,
    input  logic               wr_bit
);

    // Row k holds bit k of every entry.
    logic [ENTRIES-1:0] rows_q [KEY_W];
    logic [ENTRIES-1:0] patched;

    assign rd_row = rows_q[rd_sel];

    // Read-modify-write: fetch the row, replace one column, store it back.
    always_comb begin
        patched         = rows_q[wr_sel];
        patched[wr_col] = wr_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < KEY_W; r++) rows_q[r] <= '0;
        end else if (wr_en) begin
            rows_q[wr_sel] <= patched;
        end
    end

    // R2: a write step leaves the addressed bit equal to the written value
    a_r2_cell_written: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rows_q[$past(wr_sel)][$past(wr_col)] == $past(wr_bit));

endmodule

// File: rtl/bs_cam_match.sv
module bs_cam_match #(
    parameter int unsigned ENTRIES = 1024
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [ENTRIES-1:0] load_vec,
    input  logic               step,
    input  logic [ENTRIES-1:0] row,
    input  logic               key_bit,
    output logic [ENTRIES-1:0] match_q
);

    logic [ENTRIES-1:0] agree;

    assign agree = ~(row ^ {ENTRIES{key_bit}});

    always_ff @(posedge clk) begin
        if (rst)       match_q <= '0;
        else if (load) match_q <= load_vec;
        else if (step) match_q <= match_q & agree;
    end

    // R3: without a reload, no flag may return once cleared
    a_r3_flags_sticky: assert property (@(posedge clk) disable iff (rst)
        !load |=> (match_q & ~$past(match_q)) == '0);

endmodule

// File: rtl/bs_cam_ffs.sv
module bs_cam_ffs #(
    parameter int unsigned ENTRIES = 1024,
    parameter int unsigned IW      = 10
) (
    input  logic [ENTRIES-1:0] vec,
    output logic               any,
    output logic [IW-1:0]      idx
);

    // Scan from the top so the lowest set bit wins.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/bs_cam_top.sv
module bs_cam_top
    import bs_cam_pkg::*;
#(
    parameter int unsigned KEY_W   = KEY_W_DEFAULT,
    parameter int unsigned ENTRIES = ENTRIES_DEFAULT,
    localparam int unsigned IW     = idx_bits(ENTRIES),
    localparam int unsigned CW     = idx_bits(KEY_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             srch_start,
    input  logic             key_vld,
    input  logic             key_bit,
    input  logic             wr_req,
    input  logic [IW-1:0]    wr_idx,
    input  logic [KEY_W-1:0] wr_key,
    output logic             busy,
    output logic             done,
    output logic             hit,
    output logic [IW-1:0]    hit_idx
);

    localparam logic [CW-1:0] LAST_BIT = CW'(KEY_W - 1);

    cam_state_e         state_q;
    logic [CW-1:0]      cnt_q;
    logic [IW-1:0]      wr_idx_q;
    logic [KEY_W-1:0]   wr_key_q;
    logic [ENTRIES-1:0] valid_q;

    logic [ENTRIES-1:0] row;
    logic [ENTRIES-1:0] match_q;
    logic               any;
    logic [IW-1:0]      first_idx;
    logic               take_srch, take_wr, step, wr_step;

    assign take_srch = (state_q == ST_IDLE) && srch_start;
    assign take_wr   = (state_q == ST_IDLE) && !srch_start && wr_req;
    assign step      = (state_q == ST_SRCH) && key_vld;
    assign wr_step   = (state_q == ST_WRITE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            wr_idx_q <= '0;
            wr_key_q <= '0;
            valid_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (take_srch) begin
                        state_q <= ST_SRCH;
                    end else if (take_wr) begin
                        state_q  <= ST_WRITE;
                        wr_idx_q <= wr_idx;
                        wr_key_q <= wr_key;
                    end
                end
                ST_SRCH: begin
                    if (key_vld) begin
                        if (cnt_q == LAST_BIT) state_q <= ST_FIN;
                        else                   cnt_q   <= cnt_q + 1'b1;
                    end
                end
                ST_WRITE: begin
                    if (cnt_q == LAST_BIT) begin
                        valid_q[wr_idx_q] <= 1'b1;
                        state_q           <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_FIN: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    bs_cam_rows #(.KEY_W(KEY_W), .ENTRIES(ENTRIES), .CW(CW), .IW(IW)) u_rows (
        .clk    (clk),
        .rst    (rst),
        .rd_sel (cnt_q),
        .rd_row (row),
        .wr_en  (wr_step),
        .wr_sel (cnt_q),
        .wr_col (wr_idx_q),
        .wr_bit (wr_key_q[cnt_q])
    );

    bs_cam_match #(.ENTRIES(ENTRIES)) u_match (
        .clk      (clk),
        .rst      (rst),
        .load     (take_srch),
        .load_vec (valid_q),
        .step     (step),
        .row      (row),
        .key_bit  (key_bit),
        .match_q  (match_q)
    );

    bs_cam_ffs #(.ENTRIES(ENTRIES), .IW(IW)) u_ffs (
        .vec (match_q),
        .any (any),
        .idx (first_idx)
    );

    assign busy    = (state_q != ST_IDLE);
    assign done    = (state_q == ST_FIN);
    assign hit     = done && any;
    assign hit_idx = hit ? first_idx : '0;

    // R3: completion is a single-cycle pulse
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3: completion follows a consumed key bit
    a_r3_done_after_bit: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(key_vld));

    // R5: the reported index names a surviving entry
    a_r5_idx_is_flagged: assert property (@(posedge clk) disable iff (rst)
        hit |-> match_q[hit_idx]);

    // R2: an idle write request alone starts a busy write
    a_r2_write_taken: assert property (@(posedge clk) disable iff (rst)
        (!busy && wr_req && !srch_start) |=> (busy && !done));

    // R8: a start strobe in idle wins over a simultaneous write
    a_r8_search_wins: assert property (@(posedge clk) disable iff (rst)
        (!busy && srch_start && wr_req) |=> (state_q == ST_SRCH));

    // R7: the latched write target holds while busy
    a_r7_target_held: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(wr_idx_q));

endmodule

// File: tb/test_bs_cam_top.sv
module test_bs_cam_top;

    localparam int W  = 48;
    localparam int N  = 1024;
    localparam int IW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          srch_start = 1'b0;
    logic          key_vld = 1'b0;
    logic          key_bit = 1'b0;
    logic          wr_req = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [W-1:0]  wr_key = '0;
    logic          busy, done, hit;
    logic [IW-1:0] hit_idx;

    int total = 0;
    int bad   = 0;

    logic [W-1:0] ref_k [N];
    logic         ref_v [N];

    always #4 clk = ~clk;

    bs_cam_top i_bs_cam_top (
        .clk(clk), .rst(rst), .srch_start(srch_start), .key_vld(key_vld),
        .key_bit(key_bit), .wr_req(wr_req), .wr_idx(wr_idx), .wr_key(wr_key),
        .busy(busy), .done(done), .hit(hit), .hit_idx(hit_idx)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int ref_find(input logic [W-1:0] k);
        for (int i = 0; i < N; i++)
            if (ref_v[i] && ref_k[i] == k) return i;
        return -1;
    endfunction

    function automatic logic [W-1:0] rnd_key();
        return {16'($urandom), $urandom};
    endfunction

    // Write; optionally pulse a search start mid-way (must be ignored).
    task automatic do_write(input int idx, input logic [W-1:0] k, input bit poke);
        int cyc;
        bit saw_done;
        @(negedge clk);
        wr_req = 1'b1; wr_idx = IW'(idx); wr_key = k;
        @(negedge clk);
        wr_req = 1'b0;
        cyc = 0; saw_done = 0;
        while (busy && cyc < 4 * W) begin
            cyc++;
            if (poke && cyc == 5) begin srch_start = 1'b1; key_vld = 1'b1; end
            else begin srch_start = 1'b0; key_vld = 1'b0; end
            if (done) saw_done = 1;
            @(negedge clk);
        end
        srch_start = 1'b0; key_vld = 1'b0;
        chk(cyc == W, "R2", "write busy cycles", cyc, W);
        if (poke) chk(!saw_done && !busy, "R7", "start during write taken", saw_done, 0);
        ref_k[idx] = k; ref_v[idx] = 1'b1;
    endtask

    // Search; stall_pct inserts idle cycles, wr_poke tries a write mid-search,
    // with_wr raises wr_req together with the start strobe.
    task automatic do_search(input logic [W-1:0] k, input int stall_pct,
                             input bit wr_poke, input bit with_wr,
                             input int wp_idx, input string req);
        int e;
        @(negedge clk);
        srch_start = 1'b1;
        if (with_wr) begin wr_req = 1'b1; wr_idx = IW'(wp_idx); wr_key = k; end
        @(negedge clk);
        srch_start = 1'b0; wr_req = 1'b0;
        for (int b = 0; b < W; b++) begin
            while (int'($urandom_range(99)) < stall_pct) begin
                key_vld = 1'b0;
                @(negedge clk);
                chk(!done, "R3", "done during stall", done, 0);
            end
            key_vld = 1'b1; key_bit = k[b];
            if (wr_poke && b == 10) begin
                wr_req = 1'b1; wr_idx = IW'(wp_idx); wr_key = k;
            end else wr_req = 1'b0;
            @(negedge clk);
            if (b < W - 1) chk(!done, "R3", "early done", done, 0);
        end
        key_vld = 1'b0; wr_req = 1'b0;
        e = ref_find(k);
        chk(done, "R3", "done after last bit", done, 1);
        chk(hit == (e >= 0), req, "hit", hit, e >= 0);
        chk(int'(hit_idx) == ((e >= 0) ? e : 0), req, "hit_idx", hit_idx, (e >= 0) ? e : 0);
        @(negedge clk);
        chk(!done && !busy, "R3", "done pulse width", done, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [W-1:0] ka, kb, kc, kd, ke, kf;
        void'($urandom(32'd20251));
        for (int i = 0; i < N; i++) begin ref_k[i] = '0; ref_v[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy, "R1", "busy after reset", busy, 0);
        chk(!done, "R1", "done after reset", done, 0);

        // R9/R6: zero contents but invalid -> no hit, index 0
        do_search('0, 0, 0, 0, 0, "R9");
        do_search(rnd_key(), 0, 0, 0, 0, "R6");

        // R4: entry 0 and last entry
        ka = rnd_key(); kb = rnd_key();
        do_write(0, ka, 0);
        do_search(ka, 0, 0, 0, 0, "R4");
        do_write(N - 1, kb, 0);
        do_search(kb, 20, 0, 0, 0, "R4");

        // R5: duplicates, lower index reported
        kc = rnd_key();
        do_write(9, kc, 0);
        do_write(5, kc, 0);
        do_search(kc, 0, 0, 0, 0, "R5");

        // R10: overwrite replaces the old key
        kd = rnd_key();
        do_write(5, kd, 0);
        do_search(kc, 0, 0, 0, 0, "R10");
        do_search(kd, 0, 0, 0, 0, "R10");

        // R7: write during search dropped; start during write dropped
        ke = rnd_key();
        do_search(ke, 0, 1, 0, 20, "R7");
        do_search(ke, 0, 0, 0, 0, "R7");
        do_write(40, rnd_key(), 1);

        // R8: simultaneous start and write, search wins
        kf = rnd_key();
        do_search(kf, 0, 0, 1, 30, "R8");
        do_search(kf, 0, 0, 0, 0, "R8");

        // Random mix
        for (int n = 0; n < 90; n++) begin
            if ($urandom_range(2) == 0) begin
                do_write(int'($urandom_range(N - 1)),
                         ($urandom_range(3) == 0) ? ka : rnd_key(), 0);
            end else begin
                int pick;
                pick = int'($urandom_range(N - 1));
                if (ref_v[pick] && $urandom_range(2) != 0)
                    do_search(ref_k[pick], 15, 0, 0, 0, "R4");
                else
                    do_search(rnd_key(), 15, 0, 0, 0, "R6");
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule